// File: doc/BRIEF.md
# Serial Command Register Slave

This block lets an external host read and write a bank of 16-bit registers over a four-wire serial link: an active-low select, a serial clock, a serial input and a serial output with its own drive enable. Each transaction starts with an 8-bit instruction, then an 8-bit word address, then a 16-bit data word. All fields travel most significant bit first. The host changes its input while the serial clock is low, and the block samples it on the rising edge. On the register side the block presents an address, write data and a one-cycle write strobe, and it takes back the read data for the current address.

All three serial pins pass through synchronizers into the system clock domain, and both serial clock edges are detected there. The serial clock must therefore stay high for at least four system clocks and stay low for at least four system clocks. A read that is kept selected past its first word keeps going: the block moves to the next word address and streams that register out, and it continues this way until select rises. The address wraps from 0xFF to 0x00.

Top module: `scs_slave`

## Requirements
- R1: Instruction 0x02 is a write. Once the 16th data bit is sampled, the block pulses `rf_we` high for exactly one system clock. During that pulse `rf_addr` holds the received address byte and `rf_wdata` holds the received word, assembled MSB first.
- R2: Instruction 0x03 is a read. The word at the received address appears on `sdo` MSB first. Each bit changes after a falling edge of `sck` and is valid at the next rising edge. The first bit is valid at the rising edge that follows the last address bit.
- R3: While select stays low after a read word, the word address goes up by one and that register's word follows at once on `sdo`. The address wraps from 0xFF to 0x00.
- R4: During the read data phase the value on `sdi` has no effect: no write happens and the output words are unchanged.
- R5: If select rises before the 16th data bit of a write, nothing is written.
- R6: For any instruction other than 0x02 or 0x03, the block ignores the rest of the transaction: `sdo_en` stays low and no write happens.
- R7: While select is high, `sdo_en` is low and the bit position is cleared. A transaction cut off at any bit leaves no trace, and the next transaction decodes normally.
- R8: After the one data word of a write, the block ignores every further bit until select rises. No second write happens.
- R9: After reset, `sdo_en` and `rf_we` are low.
- R10: `sdo_en` is high only in the data phase of a read, and it is high for every bit of that phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock, idles low |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| sdo_en | output | 1 | Drive enable for sdo (low means high impedance) |
| rf_addr | output | 8 | Register word address |
| rf_wdata | output | 16 | Register write data |
| rf_we | output | 1 | One-cycle register write strobe |
| rf_rdata | input | 16 | Register read data for rf_addr |

## Verification
The hardest case to reach is the boundary between words of a read that keeps going. At that point the address steps, the next word is fetched and its MSB has to be on `sdo` by the very next falling edge. The whole sequence happens inside one serial clock period and crosses the 0xFF to 0x00 wrap. The stimulus starts a three-word read at 0xFE while it toggles `sdi` with junk. It then compares every bit against words the bench predicted for 0xFE, 0xFF and 0x00. Transactions cut off after the instruction's fifth bit and in the middle of a write's data word show that the bit position is cleared.

// File: rtl/scs_pkg.sv
package scs_pkg;

  typedef enum logic [2:0] {
    PH_CMD   = 3'd0,
    PH_ADDR  = 3'd1,
    PH_RDATA = 3'd2,
    PH_WDATA = 3'd3,
    PH_DROP  = 3'd4
  } phase_t;

  typedef enum logic [1:0] {
    OPK_RD  = 2'd0,
    OPK_WR  = 2'd1,
    OPK_BAD = 2'd2
  } op_kind_t;

  localparam logic [7:0] OPC_READ  = 8'h03;
  localparam logic [7:0] OPC_WRITE = 8'h02;

  // Maps an instruction byte to what the block does with it
  function automatic op_kind_t decode_op(input logic [7:0] op);
    if (op == OPC_READ)       return OPK_RD;
    else if (op == OPC_WRITE) return OPK_WR;
    else                      return OPK_BAD;
  endfunction

endpackage

// File: rtl/scs_sync.sv
module scs_sync #(
  parameter int          N       = 3,
  parameter int          STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);

  logic [N-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else if (s == 0) stage_q[s] <= din;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/scs_frame.sv
module scs_frame
  import scs_pkg::*;
#(
  parameter int OP_W   = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sck_rise,
  input  logic              sdi_s,
  output phase_t            phase,
  output logic [ADDR_W-1:0] rf_addr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              rf_we,
  output logic              evt_rd_start,
  output logic              evt_rword_done
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] OP_LAST   = CNT_W'(OP_W - 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] rx_sh;
  logic [DATA_W-1:0] rx_next;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_sel;
  logic              evt_op_done;
  logic              evt_addr_done;
  logic              evt_wword_done;

  function automatic logic [ADDR_W-1:0] addr_inc(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  assign rx_next        = {rx_sh[DATA_W-2:0], sdi_s};
  assign evt_op_done    = sck_rise && (phase == PH_CMD)   && (bit_cnt == OP_LAST);
  assign evt_addr_done  = sck_rise && (phase == PH_ADDR)  && (bit_cnt == ADDR_LAST);
  assign evt_rword_done = sck_rise && (phase == PH_RDATA) && (bit_cnt == DATA_LAST);
  assign evt_wword_done = sck_rise && (phase == PH_WDATA) && (bit_cnt == DATA_LAST);
  assign evt_rd_start   = evt_addr_done && rd_sel;
  assign rf_addr        = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_CMD;
      bit_cnt  <= '0;
      rx_sh    <= '0;
      addr_q   <= '0;
      rd_sel   <= 1'b0;
      rf_wdata <= '0;
      rf_we    <= 1'b0;
    end else begin
      rf_we <= 1'b0;
      if (!cs_act) begin
        phase   <= PH_CMD;
        bit_cnt <= '0;
      end else if (sck_rise) begin
        rx_sh   <= rx_next;
        bit_cnt <= bit_cnt + CNT_W'(1);
        unique case (phase)
          PH_CMD: begin
            if (evt_op_done) begin
              bit_cnt <= '0;
              unique case (decode_op(rx_next[OP_W-1:0]))
                OPK_RD:  begin phase <= PH_ADDR; rd_sel <= 1'b1; end
                OPK_WR:  begin phase <= PH_ADDR; rd_sel <= 1'b0; end
                default: phase <= PH_DROP;
              endcase
            end
          end
          PH_ADDR: begin
            if (evt_addr_done) begin
              bit_cnt <= '0;
              addr_q  <= rx_next[ADDR_W-1:0];
              phase   <= rd_sel ? PH_RDATA : PH_WDATA;
            end
          end
          PH_RDATA: begin
            if (evt_rword_done) begin
              bit_cnt <= '0;
              addr_q  <= addr_inc(addr_q);
            end
          end
          PH_WDATA: begin
            if (evt_wword_done) begin
              bit_cnt  <= '0;
              rf_wdata <= rx_next;
              rf_we    <= 1'b1;
              phase    <= PH_DROP;
            end
          end
          default: bit_cnt <= '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/scs_tx.sv
module scs_tx #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              in_rd,
  input  logic              load_req,
  input  logic              sck_fall,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              sdo,
  output logic              sdo_en
);

  logic [DATA_W-1:0] tx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh  <= '0;
      sdo    <= 1'b0;
      sdo_en <= 1'b0;
    end else if (!cs_act || !in_rd) begin
      tx_sh  <= '0;
      sdo    <= 1'b0;
      sdo_en <= 1'b0;
    end else begin
      sdo_en <= 1'b1;
      if (load_req) begin
        tx_sh <= rf_rdata;
      end else if (sck_fall) begin
        sdo   <= tx_sh[DATA_W-1];
        tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
      end
    end
  end

endmodule

// File: rtl/scs_slave.sv
module scs_slave
  import scs_pkg::*;
#(
  parameter int OP_W        = 8,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_en,
  output logic [ADDR_W-1:0] rf_addr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              rf_we,
  input  logic [DATA_W-1:0] rf_rdata
);

  logic [2:0] pins_s;
  logic       cs_n_s, sck_s, sdi_s, sck_d;
  logic       cs_act, sck_rise, sck_fall;
  logic       in_rd, load_req;
  logic       evt_rd_start, evt_rword_done;
  phase_t     phase;

  scs_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({cs_n, sck, sdi}),
    .dout (pins_s)
  );

  assign {cs_n_s, sck_s, sdi_s} = pins_s;
  assign cs_act   = ~cs_n_s;
  assign sck_rise = cs_act & sck_s & ~sck_d;
  assign sck_fall = cs_act & ~sck_s & sck_d;
  assign in_rd    = (phase == PH_RDATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d    <= 1'b0;
      load_req <= 1'b0;
    end else begin
      sck_d    <= sck_s;
      load_req <= evt_rd_start | evt_rword_done;
    end
  end

  scs_frame #(.OP_W(OP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk           (clk),
    .rst_n         (rst_n),
    .cs_act        (cs_act),
    .sck_rise      (sck_rise),
    .sdi_s         (sdi_s),
    .phase         (phase),
    .rf_addr       (rf_addr),
    .rf_wdata      (rf_wdata),
    .rf_we         (rf_we),
    .evt_rd_start  (evt_rd_start),
    .evt_rword_done(evt_rword_done)
  );

  scs_tx #(.DATA_W(DATA_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_act  (cs_act),
    .in_rd   (in_rd),
    .load_req(load_req),
    .sck_fall(sck_fall),
    .rf_rdata(rf_rdata),
    .sdo     (sdo),
    .sdo_en  (sdo_en)
  );

endmodule

// File: rtl/scs_slave_chk.sv
module scs_slave_chk
  import scs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_act,
  input logic              sck_fall,
  input logic              sdo,
  input logic              sdo_en,
  input logic              rf_we,
  input logic [ADDR_W-1:0] rf_addr,
  input logic              evt_rword_done,
  input logic              in_rd,
  input phase_t            phase
);

  // R7
  idle_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !sdo_en);

  // R1
  we_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we);

  // R8
  we_then_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (phase == PH_DROP));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rword_done |=> (rf_addr == $past(rf_addr) + ADDR_W'(1)));

  // R10
  en_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_en |-> $past(in_rd));

  // R2
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_en && $past(sdo_en) && !$past(sck_fall)) |-> $stable(sdo));

  // R6
  drop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DROP) |-> !sdo_en);

endmodule

bind scs_slave scs_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cs_act        (cs_act),
  .sck_fall      (sck_fall),
  .sdo           (sdo),
  .sdo_en        (sdo_en),
  .rf_we         (rf_we),
  .rf_addr       (rf_addr),
  .evt_rword_done(evt_rword_done),
  .in_rd         (in_rd),
  .phase         (phase)
);

// File: tb/scs_slave_test.sv
module scs_slave_test;

  localparam int H = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sck = 1'b0;
  logic        sdi = 1'b0;
  logic        sdo, sdo_en, rf_we;
  logic [7:0]  rf_addr;
  logic [15:0] rf_wdata, rf_rdata;

  logic [15:0] regs [256];
  logic [15:0] exp_mem [256];
  int          total = 0;
  int          bad = 0;
  bit          exp_pend = 1'b0;
  logic [7:0]  exp_addr;
  logic [15:0] exp_data;
  int          idle_cnt = 0;

  always #2 clk = ~clk;

  scs_slave uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .sdo(sdo), .sdo_en(sdo_en), .rf_addr(rf_addr), .rf_wdata(rf_wdata),
    .rf_we(rf_we), .rf_rdata(rf_rdata)
  );

  function automatic logic [15:0] init_val(input int i);
    return 16'h1000 ^ 16'(i * 16'h0101) ^ 16'(i << 3);
  endfunction

  assign rf_rdata = regs[rf_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) regs[i] <= init_val(i);
    end else if (rf_we) begin
      regs[rf_addr] <= rf_wdata;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Per-clock reference comparison
  always @(negedge clk) begin
    if (rst_n) begin
      idle_cnt = cs_n ? idle_cnt + 1 : 0;
      if (idle_cnt >= 4) check(!sdo_en, "R7 idle drive", 32'(sdo_en), 0);
      if (rf_we) begin
        check(exp_pend, "R4 R5 R6 R8 unexpected write", 32'(rf_addr), 32'hffff);
        if (exp_pend) begin
          check(rf_addr == exp_addr, "R1 write addr", 32'(rf_addr), 32'(exp_addr));
          check(rf_wdata == exp_data, "R1 write data", 32'(rf_wdata), 32'(exp_data));
          exp_pend = 1'b0;
        end
      end
    end
  end

  task automatic clk_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer_bit(input logic b, output logic so, output logic so_en);
    sdi = b;
    clk_wait(H);
    so = sdo;
    so_en = sdo_en;
    sck = 1'b1;
    clk_wait(H);
    sck = 1'b0;
  endtask

  task automatic sel;
    cs_n = 1'b0;
    clk_wait(H);
  endtask

  task automatic desel;
    clk_wait(H);
    cs_n = 1'b1;
    clk_wait(4 * H);
  endtask

  task automatic send_bits(input logic [15:0] v, input int n, input bit expect_quiet, input string req);
    logic so, se;
    for (int i = n - 1; i >= 0; i--) begin
      xfer_bit(v[i], so, se);
      if (expect_quiet) check(!se, req, 32'(se), 0);
    end
  endtask

  task automatic write_word(input logic [7:0] a, input logic [15:0] d, input int extra);
    sel();
    send_bits(16'h0002, 8, 1'b1, "R10 enable during write");
    send_bits(16'(a), 8, 1'b1, "R10 enable during write");
    send_bits(d >> 1, 15, 1'b1, "R10 enable during write");
    exp_pend = 1'b1; exp_addr = a; exp_data = d; exp_mem[a] = d;
    send_bits({15'd0, d[0]}, 1, 1'b1, "R10 enable during write");
    if (extra > 0) send_bits(~d, extra, 1'b1, "R8 enable after write");
    desel();
    check(!exp_pend, "R1 write committed", 32'(exp_pend), 0);
  endtask

  task automatic read_words(input logic [7:0] a, input int n);
    logic so, se;
    logic [15:0] got;
    sel();
    send_bits(16'h0003, 8, 1'b1, "R10 enable before data");
    send_bits(16'(a), 8, 1'b0, "");
    for (int w = 0; w < n; w++) begin
      got = '0;
      for (int i = 15; i >= 0; i--) begin
        xfer_bit(logic'((i + w) % 2), so, se);
        got[i] = so;
        check(se, "R10 enable in read", 32'(se), 1);
      end
      if (w == 0) check(got == exp_mem[a], "R2 R4 read word", 32'(got), 32'(exp_mem[a]));
      else check(got == exp_mem[8'(a + w)], "R3 R4 next word", 32'(got), 32'(exp_mem[8'(a + w)]));
    end
    desel();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
    clk_wait(5);
    // R9 reset state
    check(!sdo_en, "R9 sdo_en", 32'(sdo_en), 0);
    check(!rf_we, "R9 rf_we", 32'(rf_we), 0);
    rst_n = 1'b1;
    clk_wait(10);

    write_word(8'h10, 16'hA5C3, 0);        // R1
    read_words(8'h10, 1);                  // R2
    read_words(8'h42, 1);                  // R2 untouched register
    read_words(8'hFE, 3);                  // R3 wrap, R4 junk on sdi

    // R5: partial write data
    sel();
    send_bits(16'h0002, 8, 1'b1, "R10");
    send_bits(16'h0020, 8, 1'b1, "R10");
    send_bits(16'h3FF, 10, 1'b1, "R10");
    desel();
    check(regs[8'h20] == exp_mem[8'h20], "R5 partial discarded", 32'(regs[8'h20]), 32'(exp_mem[8'h20]));

    // R6: unknown opcode, then a write-like tail
    sel();
    send_bits(16'h0005, 8, 1'b1, "R6 enable");
    send_bits(16'h0030, 8, 1'b1, "R6 enable");
    send_bits(16'hBEEF, 16, 1'b1, "R6 enable");
    desel();
    check(regs[8'h30] == exp_mem[8'h30], "R6 no write", 32'(regs[8'h30]), 32'(exp_mem[8'h30]));

    // R8: bits after one write word ignored
    write_word(8'h50, 16'h1234, 16);
    check(regs[8'h51] == exp_mem[8'h51], "R8 next reg untouched", 32'(regs[8'h51]), 32'(exp_mem[8'h51]));
    check(regs[8'h50] == 16'h1234, "R8 first word kept", 32'(regs[8'h50]), 32'h1234);

    // R7: abort after 5 instruction bits, then a clean write
    sel();
    send_bits(16'h001F, 5, 1'b1, "R7 enable");
    desel();
    write_word(8'h77, 16'h0F0F, 0);
    read_words(8'h77, 1);
    read_words(8'hFF, 2);                  // R3 wrap from the last address

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule